// File: doc/BRIEF.md
# DDR burst-of-two SRAM port

This block is a synthesizable model of a pipelined synchronous SRAM whose data port runs at double data rate and moves exactly two words for every address. One system clock stands in for both halves of the input clock pair. A phase input marks each system clock edge. When `phaseHi` is 0 the edge is the rising edge of the true clock (the "K half"). When `phaseHi` is 1 it is the rising edge of the complement clock (the "K-bar half"). The host presents an address, a read/write select and a load strobe on a K half. For a write it then supplies two data beats, each with its own byte lane enables. For a read it receives two words back after a latency of one or one and a half clock periods, chosen by a mode pin.

Each location stores two words. A one-bit burst counter orders them. With `START_FROM_LSB` set, address bit 0 picks the word transferred first. With it cleared, the burst always starts at word 0. Writes sit in a write register and commit to the array on the K-bar half after the second beat, with no host handshake. A read that arrives before the commit is served from that register. An address is accepted at most on every other K half. A load offered too early is dropped and raises a sticky error flag.

Top module: `ddr2b_sram_port`

## Requirements
- R1: A load is accepted only when `ldStrobe` is high on a K half (`phaseHi`=0) and no earlier access is still running. `ldStrobe` on a K-bar half is ignored and sets no error.
- R2: After an accepted load, a load on the next K half (two edges later) is ignored. It sets `protoErr`, which stays high until reset.
- R3: For a write accepted at edge t, `wrData` is sampled at edge t+2 (K half) as the first beat and at edge t+3 (K-bar half) as the second beat. Both beats go to the location `addr[ADDR_W-1:1]`.
- R4: With `START_FROM_LSB`=1, the first beat or first read word is word `addr[0]` and the second is the other word. With `START_FROM_LSB`=0, the first is always word 0, the second is word 1, and `addr[0]` has no effect.
- R5: `byteSel[i]`=1 writes lane i (bits `[i*LANE_W +: LANE_W]`) of that beat's word. `byteSel[i]`=0 leaves that lane of the stored word unchanged.
- R6: With `latHalf`=1 at the read load edge t, the first word is on `rdData` with `rdValid` high after edge t+3 and the second word after edge t+4.
- R7: With `latHalf`=0 at the read load edge t, the first word appears after edge t+2 and the second after edge t+3.
- R8: `rdValid` is high for exactly two consecutive edges per read and low otherwise. `rdData` is zero while `rdValid` is low.
- R9: A read accepted in the load slot right after a write returns the newly written, lane-merged data.
- R10: After each edge, `echoStrobe` is 1 if that edge was a K half and 0 if it was a K-bar half.
- R11: During reset, `rdValid`, `rdData`, `protoErr` and `echoStrobe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Every rising edge is one DDR half |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseHi | input | 1 | 0: edge is a K half; 1: edge is a K-bar half |
| ldStrobe | input | 1 | Load request, sampled on K halves |
| rdWr | input | 1 | 1 = read, 0 = write, taken with an accepted load |
| addr | input | ADDR_W | Bits above 0 select the location. Bit 0 is the start word |
| latHalf | input | 1 | 1: read latency 1.5 cycles; 0: 1 cycle |
| wrData | input | WORD_W | Write data beat |
| byteSel | input | LANES | Per-lane write enables for the current beat |
| rdData | output | WORD_W | Read data word |
| rdValid | output | 1 | High while `rdData` carries a read word |
| echoStrobe | output | 1 | Registered echo of the half that launched the data |
| protoErr | output | 1 | Sticky flag for a load offered while busy |

## Verification
On every cycle, the assertions check the read latency in both modes from the internal load acceptance, the two-edge shape of every valid burst, the spacing between accepted loads, and the stickiness of the error flag. Only the bench scenarios can show that the right word comes out in the right order for both start-word settings. The same holds for partial lane writes merging with old contents, for back-to-back write-then-read forwarding, and for loads on the K-bar half or on a busy K half leaving the array untouched. Two instances run side by side, one per start-word setting, against a bench model of the array.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

  // Strobes from the control sequencer to the datapath
  typedef struct packed {
    logic capture;   // address accepted this edge
    logic isRead;    // direction of the access being accepted
    logic fetch;     // read both words of the captured location
    logic beat;      // a write data beat is on wrData
    logic launch;    // drive one read word to the output
    logic wordSel;   // word index used by beat / launch
    logic commit;    // write register goes to the array
    logic fwdOk;     // write register holds data not yet committed
  } ddr2bStrobes_t;

endpackage

// File: rtl/ddr2b_ctrl.sv
module ddr2b_ctrl
  import ddr2b_pkg::*;
#(
  parameter bit START_FROM_LSB = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          phaseHi,
  input  logic          ldStrobe,
  input  logic          rdWr,
  input  logic          addrLsb,
  input  logic          latHalf,
  output ddr2bStrobes_t strobes,
  output logic          protoErr,
  output logic          echoStrobe
);

  localparam int AGE_N = 4;

  logic [AGE_N-1:0] rdAge;
  logic [AGE_N-1:0] wrAge;
  logic             latReg;
  logic             opStart;
  logic             pendValid;

  logic busy;
  logic kLoad;
  logic accept;
  logic startIn;
  logic launchFirst;
  logic launchSecond;
  logic beatFirst;
  logic beatSecond;
  logic commitNow;

  // An access occupies the K half it is loaded on plus one more K cycle
  assign busy    = (|rdAge[AGE_N-2:0]) | (|wrAge[AGE_N-2:0]);
  assign kLoad   = ldStrobe && !phaseHi;
  assign accept  = kLoad && !busy;
  assign startIn = START_FROM_LSB ? addrLsb : 1'b0;

  // Read launch edges relative to the load edge t: +2/+3 or +3/+4
  assign launchFirst  = latReg ? rdAge[2] : rdAge[1];
  assign launchSecond = latReg ? rdAge[3] : rdAge[2];

  // Write beats at t+2 (K half) and t+3 (K-bar half)
  assign beatFirst  = wrAge[1];
  assign beatSecond = wrAge[2];

  // Self-timed commit on the next K-bar half after the second beat
  assign commitNow = pendValid && phaseHi;

  always_comb begin
    strobes         = '0;
    strobes.capture = accept;
    strobes.isRead  = rdWr;
    strobes.fetch   = rdAge[0];
    strobes.beat    = beatFirst | beatSecond;
    strobes.launch  = launchFirst | launchSecond;
    strobes.wordSel = (beatSecond | launchSecond) ? !opStart : opStart;
    strobes.commit  = commitNow;
    strobes.fwdOk   = pendValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAge      <= '0;
      wrAge      <= '0;
      latReg     <= 1'b0;
      opStart    <= 1'b0;
      pendValid  <= 1'b0;
      protoErr   <= 1'b0;
      echoStrobe <= 1'b0;
    end else begin
      rdAge      <= {rdAge[AGE_N-2:0], accept && rdWr};
      wrAge      <= {wrAge[AGE_N-2:0], accept && !rdWr};
      echoStrobe <= !phaseHi;
      if (accept) begin
        latReg  <= latHalf;
        opStart <= startIn;
      end
      if (beatSecond) begin
        pendValid <= 1'b1;
      end else if (commitNow) begin
        pendValid <= 1'b0;
      end
      if (kLoad && busy) begin
        protoErr <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr2b_datapath.sv
module ddr2b_datapath
  import ddr2b_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 64,
  localparam int LOC_W  = $clog2(DEPTH),
  localparam int ADDR_W = LOC_W + 1,
  localparam int LANES  = WORD_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ddr2bStrobes_t     strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LANES-1:0]  byteSel,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);

  logic [LOC_W-1:0]  locReg;
  logic [LOC_W-1:0]  pendLoc;
  logic [WORD_W-1:0] laneMask;
  logic              pendHit;

  // Expand per-lane selects into a bit mask
  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign laneMask[i*LANE_W +: LANE_W] = {LANE_W{byteSel[i]}};
  end

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      locReg <= addr[ADDR_W-1:1];
    end
    if (strobes.beat) begin
      pendLoc <= locReg;
    end
  end

  assign pendHit = strobes.fwdOk && (pendLoc == locReg);

  // One bank per burst word
  for (genvar w = 0; w < 2; w++) begin : bankGen
    localparam bit WSEL = (w == 1);

    logic [WORD_W-1:0] bank [DEPTH];
    logic [WORD_W-1:0] pendWord;
    logic [WORD_W-1:0] pendMaskW;
    logic [WORD_W-1:0] bufWord;
    logic [WORD_W-1:0] arrWord;
    logic [WORD_W-1:0] fetched;
    logic [WORD_W-1:0] commitWord;

    assign arrWord    = bank[locReg];
    assign commitWord = (bank[pendLoc] & ~pendMaskW) | (pendWord & pendMaskW);
    assign fetched    = pendHit ? ((arrWord & ~pendMaskW) | (pendWord & pendMaskW))
                                : arrWord;

    always_ff @(posedge clk) begin
      if (strobes.commit) begin
        bank[pendLoc] <= commitWord;
      end
      if (strobes.beat && (strobes.wordSel == WSEL)) begin
        pendWord  <= wrData;
        pendMaskW <= laneMask;
      end
      if (strobes.fetch) begin
        bufWord <= fetched;
      end
    end
  end

  logic [WORD_W-1:0] launchWord;
  assign launchWord = strobes.wordSel ? bankGen[1].bufWord : bankGen[0].bufWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.launch;
      rdData  <= strobes.launch ? launchWord : '0;
    end
  end

endmodule

// File: rtl/ddr2b_sram_port.sv
module ddr2b_sram_port
  import ddr2b_pkg::*;
#(
  parameter int WORD_W         = 18,
  parameter int LANE_W         = 9,
  parameter int DEPTH          = 64,
  parameter bit START_FROM_LSB = 1'b1,
  localparam int LOC_W  = $clog2(DEPTH),
  localparam int ADDR_W = LOC_W + 1,
  localparam int LANES  = WORD_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseHi,
  input  logic              ldStrobe,
  input  logic              rdWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              latHalf,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LANES-1:0]  byteSel,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              echoStrobe,
  output logic              protoErr
);

  ddr2bStrobes_t ctrlBus;

  ddr2b_ctrl #(
    .START_FROM_LSB(START_FROM_LSB)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .phaseHi   (phaseHi),
    .ldStrobe  (ldStrobe),
    .rdWr      (rdWr),
    .addrLsb   (addr[0]),
    .latHalf   (latHalf),
    .strobes   (ctrlBus),
    .protoErr  (protoErr),
    .echoStrobe(echoStrobe)
  );

  ddr2b_datapath #(
    .WORD_W(WORD_W),
    .LANE_W(LANE_W),
    .DEPTH (DEPTH)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(ctrlBus),
    .addr   (addr),
    .wrData (wrData),
    .byteSel(byteSel),
    .rdData (rdData),
    .rdValid(rdValid)
  );

endmodule

// File: rtl/ddr2b_sram_port_chk.sv
module ddr2b_sram_port_chk (
  input logic clk,
  input logic rstN,
  input logic latHalf,
  input logic rdValid,
  input logic protoErr,
  input logic capture,
  input logic isRead
);

  AST_LAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (capture && isRead && !latHalf) |-> ##3 (rdValid && !$past(rdValid))); // R7

  AST_LAT_HALF_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (capture && isRead && latHalf) |-> ##4 (rdValid && !$past(rdValid))); // R6

  AST_BURST_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |=> rdValid); // R8

  AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdValid)) |=> !rdValid); // R8

  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> (!capture ##1 !capture ##1 !capture)); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R2

endmodule

bind ddr2b_sram_port ddr2b_sram_port_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .latHalf (latHalf),
  .rdValid (rdValid),
  .protoErr(protoErr),
  .capture (ctrlBus.capture),
  .isRead  (ctrlBus.isRead)
);

// File: tb/tb_ddr2b_sram_port.sv
module tb_ddr2b_sram_port;

  localparam int CLK_P = 10;
  localparam int W     = 18;
  localparam int LW    = 9;
  localparam int DEP   = 64;
  localparam int AW    = 7;
  localparam int LN    = 2;

  logic          clk;
  logic          rstN;
  logic          phaseHi;
  logic          ldStrobe;
  logic          rdWr;
  logic [AW-1:0] addr;
  logic          latHalf;
  logic [W-1:0]  wrData;
  logic [LN-1:0] byteSel;

  logic [W-1:0]  rdDataA, rdDataZ;
  logic          rdValidA, rdValidZ;
  logic          echoA, echoZ;
  logic          errA, errZ;

  ddr2b_sram_port #(.WORD_W(W), .LANE_W(LW), .DEPTH(DEP), .START_FROM_LSB(1'b1)) dut (
    .clk(clk), .rstN(rstN), .phaseHi(phaseHi), .ldStrobe(ldStrobe), .rdWr(rdWr),
    .addr(addr), .latHalf(latHalf), .wrData(wrData), .byteSel(byteSel),
    .rdData(rdDataA), .rdValid(rdValidA), .echoStrobe(echoA), .protoErr(errA));

  ddr2b_sram_port #(.WORD_W(W), .LANE_W(LW), .DEPTH(DEP), .START_FROM_LSB(1'b0)) dutZ (
    .clk(clk), .rstN(rstN), .phaseHi(phaseHi), .ldStrobe(ldStrobe), .rdWr(rdWr),
    .addr(addr), .latHalf(latHalf), .wrData(wrData), .byteSel(byteSel),
    .rdData(rdDataZ), .rdValid(rdValidZ), .echoStrobe(echoZ), .protoErr(errZ));

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  logic [W-1:0] mA [DEP][2];
  logic [W-1:0] mZ [DEP][2];

  bit           expV   [16];
  logic [W-1:0] expA   [16];
  logic [W-1:0] expZ   [16];
  string        expTag [16];

  int tk     = 0;
  int total  = 0;
  int bad    = 0;
  int errAt  = -1;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R8 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  function automatic logic [W-1:0] mergeW(input logic [W-1:0] old,
                                          input logic [W-1:0] nw,
                                          input logic [LN-1:0] m);
    logic [W-1:0] r;
    r = old;
    for (int i = 0; i < LN; i++) begin
      if (m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s tick=%0d act=%h exp=%h", tag, what, tk, act, exp);
    end
  endtask

  task automatic sampleNow();
    int s;
    bit eE;
    bit eEcho;
    string vTag;
    logic [W-1:0] xA;
    logic [W-1:0] xZ;
    s     = tk % 16;
    vTag  = expV[s] ? expTag[s] : "R8";
    xA    = expV[s] ? expA[s] : '0;
    xZ    = expV[s] ? expZ[s] : '0;
    chk(rdValidA === expV[s], vTag, "rdValid", W'(rdValidA), W'(expV[s]));
    chk(rdDataA === xA, vTag, "rdData", rdDataA, xA);
    chk(rdValidZ === expV[s], {vTag, " R4"}, "rdValidZ", W'(rdValidZ), W'(expV[s]));
    chk(rdDataZ === xZ, {vTag, " R4"}, "rdDataZ", rdDataZ, xZ);
    // R10: echo reflects the half of the edge just passed
    eEcho = ((tk - 1) % 2) == 0;
    chk(echoA === eEcho, "R10", "echo", W'(echoA), W'(eEcho));
    chk(echoZ === eEcho, "R10", "echoZ", W'(echoZ), W'(eEcho));
    eE = (errAt >= 0) && (tk >= errAt);
    chk(errA === eE, (errAt < 0) ? "R1 R2" : "R2", "protoErr", W'(errA), W'(eE));
    chk(errZ === eE, (errAt < 0) ? "R1 R2" : "R2", "protoErrZ", W'(errZ), W'(eE));
    expV[s] = 1'b0;
  endtask

  task automatic step(input bit ld, input bit rw, input logic [AW-1:0] a, input bit lat,
                      input logic [W-1:0] d, input logic [LN-1:0] m);
    @(negedge clk);
    if (tk > 0) sampleNow();
    phaseHi  = (tk % 2) == 1;
    ldStrobe = ld;
    rdWr     = rw;
    addr     = a;
    latHalf  = lat;
    wrData   = d;
    byteSel  = m;
    tk++;
  endtask

  task automatic idle2();
    step(1'b0, 1'b0, '0, 1'b0, '0, '0);
    step(1'b0, 1'b0, '0, 1'b0, '0, '0);
  endtask

  // One access of four ticks starting on a K half
  task automatic op(input bit isRd, input logic [AW-1:0] a, input bit lat,
                    input logic [W-1:0] d0, input logic [W-1:0] d1,
                    input logic [LN-1:0] m0, input logic [LN-1:0] m1,
                    input bit injBusy, input bit injPh, input string tag);
    int t;
    int k;
    int loc;
    bit st;
    t   = tk;
    loc = int'(a[AW-1:1]);
    st  = a[0];
    if (isRd) begin
      k = lat ? t + 4 : t + 3;
      expV[k % 16]       = 1'b1;
      expA[k % 16]       = mA[loc][st];
      expZ[k % 16]       = mZ[loc][0];
      expTag[k % 16]     = tag;
      expV[(k+1) % 16]   = 1'b1;
      expA[(k+1) % 16]   = mA[loc][!st];
      expZ[(k+1) % 16]   = mZ[loc][1];
      expTag[(k+1) % 16] = tag;
    end else begin
      mA[loc][st]  = mergeW(mA[loc][st],  d0, m0);
      mA[loc][!st] = mergeW(mA[loc][!st], d1, m1);
      mZ[loc][0]   = mergeW(mZ[loc][0],   d0, m0);
      mZ[loc][1]   = mergeW(mZ[loc][1],   d1, m1);
    end
    if (injBusy && errAt < 0) errAt = t + 3;
    step(1'b1, isRd, a, lat, W'($urandom), LN'($urandom));
    step(injPh, 1'($urandom), AW'($urandom), 1'($urandom), W'($urandom), LN'($urandom));
    step(injBusy, 1'($urandom), AW'($urandom), 1'($urandom), d0, m0);
    step(1'b0, 1'($urandom), AW'($urandom), 1'($urandom), d1, m1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; phaseHi = 1'b0; ldStrobe = 1'b0; rdWr = 1'b0;
    addr = '0; latHalf = 1'b0; wrData = '0; byteSel = '0;
    for (int i = 0; i < 16; i++) expV[i] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(rdValidA === 1'b0 && rdValidZ === 1'b0, "R11", "rdValid", W'(rdValidA), '0);
    chk(rdDataA === '0 && rdDataZ === '0, "R11", "rdData", rdDataA, '0);
    chk(errA === 1'b0 && errZ === 1'b0, "R11", "protoErr", W'(errA), '0);
    chk(echoA === 1'b0 && echoZ === 1'b0, "R11", "echo", W'(echoA), '0);
    rstN = 1'b1;

    // R3: fill every location with both beats, full lanes
    for (int i = 0; i < DEP; i++) begin
      op(1'b0, AW'(2*i + int'($urandom % 2)), 1'b0, W'($urandom), W'($urandom),
         '1, '1, 1'b0, 1'b0, "R3");
    end
    // R6 R7 R4: read everything back, alternating latency and start word
    for (int i = 0; i < DEP; i++) begin
      op(1'b1, AW'(2*i + (i % 2)), i[1], '0, '0, '0, '0, 1'b0, 1'b0,
         i[1] ? "R6 R3" : "R7 R3");
    end
    // R9: write then read the same location in the next slot, both latencies
    op(1'b0, AW'(11), 1'b0, 18'h2AAAA, 18'h15555, '1, '1, 1'b0, 1'b0, "R9");
    op(1'b1, AW'(11), 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, "R9 R7");
    op(1'b0, AW'(10), 1'b1, 18'h3C3C3, 18'h0F0F0, '1, '1, 1'b0, 1'b0, "R9");
    op(1'b1, AW'(10), 1'b1, '0, '0, '0, '0, 1'b0, 1'b0, "R9 R6");
    // R5: partial lanes, forwarded and then from the array
    op(1'b0, AW'(21), 1'b0, 18'h3FFFF, 18'h3FFFF, 2'b01, 2'b10, 1'b0, 1'b0, "R5");
    op(1'b1, AW'(21), 1'b1, '0, '0, '0, '0, 1'b0, 1'b0, "R5 R9");
    op(1'b0, AW'(21), 1'b0, 18'h00000, 18'h00000, 2'b00, 2'b00, 1'b0, 1'b0, "R5");
    idle2();
    op(1'b1, AW'(20), 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, "R5 R4");
    // R1: loads on K-bar halves are ignored without an error
    op(1'b0, AW'(31), 1'b0, 18'h12345, 18'h2BCDE, '1, '1, 1'b0, 1'b1, "R1");
    op(1'b1, AW'(31), 1'b1, '0, '0, '0, '0, 1'b0, 1'b1, "R1");
    idle2();
    // R2: load on the busy K half is dropped and the flag sticks
    op(1'b0, AW'(40), 1'b0, 18'h0AAAA, 18'h35555, '1, '1, 1'b1, 1'b0, "R2");
    op(1'b1, AW'(40), 1'b0, '0, '0, '0, '0, 1'b1, 1'b0, "R2");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      bit rd;
      bit lt;
      rd = 1'($urandom);
      lt = 1'($urandom);
      op(rd, AW'($urandom), lt, W'($urandom), W'($urandom), LN'($urandom), LN'($urandom),
         ($urandom % 8) == 0, ($urandom % 5) == 0,
         rd ? (lt ? "R6 R5" : "R7 R5") : "R3");
      if (($urandom % 6) == 0) idle2();
    end
    idle2();
    idle2();
    idle2();
    summary();
    $finish;
  end

endmodule